// File: doc/BRIEF.md
# CAN Mailbox Code State Controller

This block holds the 4-bit state code of each mailbox in a bank of CAN message buffers. The CPU writes these codes. The block then changes them by itself when the protocol engine reports an event for a mailbox. There are four kinds of event:

- a finished transmission;
- a match against an incoming remote request;
- the start of a receive move-in;
- the end of a receive move-in.

Each event arrives as a one-cycle valid pulse that carries a mailbox index.

From the stored codes the block derives three things for every mailbox:

- a flag that says whether the mailbox may enter transmit arbitration;
- a busy flag, shown while a receive move-in is in progress;
- a CPU read view of the code, in which the busy bit of transmit codes is hidden unless abort is enabled.

When a CPU write is lost because the mailbox is busy, the block reports it on a one-cycle conflict flag.

Top module: `mbc_code_ctrl`

## Requirements
- R1: After synchronous reset every mailbox code is 0000 and not busy, no mailbox is eligible for transmission, and `wr_conflict` is 0.
- R2: A CPU write to a mailbox that is not busy loads the written code and RTR bit. The new code is visible on `mb_code` one cycle later.
- R3: A transmit-done event acts only on three codes; any other code is left unchanged.
  - Code 1100 with RTR 0 becomes 1000 (inactive).
  - Code 1100 with RTR 1 becomes 0100 (receive empty).
  - Code 1110 (answer pending) becomes 1010 (answer ready).
- R4: A remote-request match on a mailbox holding 1010 changes its code to 1110. On any other code the match is ignored.
- R5: A move-in start on a mailbox holding 0100, 0010 or 0110 sets code bit 0 (busy). On any other code the start is ignored. Code bits 3..1 do not change while the mailbox is busy.
- R6: A move-in end on a busy mailbox clears the busy bit and advances the receive state: 0100 becomes 0010 (full), 0010 becomes 0110 (overrun), and 0110 stays 0110. A move-in end on a mailbox that is not busy is ignored.
- R7: `tx_eligible[i]` is 1 exactly when mailbox i holds 1100 or 1110.
- R8: `mb_rd_code` equals `mb_code`, except that bit 0 reads 0 for codes with bit 3 set while `abort_en` is 0.
- R9: A CPU write of 1001 (abort) to a mailbox holding 1010 is ignored. The code stays 1010 and `wr_conflict` stays 0.
- R10: A CPU write and an event on the same mailbox in the same cycle, with the mailbox not busy, apply the CPU write. The event is dropped.
- R11: A CPU write to a busy mailbox is dropped, and any event on that mailbox in that cycle is still applied. `wr_conflict` is 1 for exactly the following cycle.
- R12: Events on the same mailbox in the same cycle resolve by priority: move-in end, then move-in start, then remote match, then transmit done. Only the highest-priority event is applied. Events on different mailboxes in the same cycle are all applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_en | input | 1 | Abort enable; shows the busy bit of transmit codes in the read view |
| cpu_wr_en | input | 1 | CPU code write strobe |
| cpu_wr_idx | input | IDX_W | Mailbox index of the CPU write |
| cpu_wr_code | input | 4 | Code to write |
| cpu_wr_rtr | input | 1 | RTR bit written with the code |
| tx_done_vld | input | 1 | Transmission completed |
| tx_done_idx | input | IDX_W | Mailbox of the completed transmission |
| rr_match_vld | input | 1 | Remote request matched |
| rr_match_idx | input | IDX_W | Mailbox of the remote-request match |
| mi_start_vld | input | 1 | Receive move-in started |
| mi_start_idx | input | IDX_W | Mailbox of the move-in start |
| mi_end_vld | input | 1 | Receive move-in finished |
| mi_end_idx | input | IDX_W | Mailbox of the move-in end |
| mb_code | output | NUM_MB*4 | Raw code of each mailbox; mailbox i is at bits 4i+3..4i |
| mb_rd_code | output | NUM_MB*4 | CPU read view of each code, same layout as `mb_code` |
| tx_eligible | output | NUM_MB | Mailbox may enter transmit arbitration |
| mb_busy | output | NUM_MB | Receive move-in in progress |
| wr_conflict | output | 1 | The previous cycle's CPU write was dropped |

## Verification
Every code change takes effect at the first clock edge after the cycle in which the write or event is presented. At that same edge the outputs that depend on the code also take their new values: `mb_code`, `mb_busy`, `tx_eligible` and `mb_rd_code` (these last three are decoded from the code registers without further delay). `wr_conflict` is registered, so it is also due one edge after the losing write, and it lasts a single cycle.

The bench drives each stimulus 1 ns after a rising edge and removes it after the next rising edge. It checks 1 ns after that edge. To confirm that the conflict flag is a single pulse, one further check is made one cycle later.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    localparam int CODE_W = 4;
    localparam int EV_W   = 3;

    typedef logic [CODE_W-1:0] code_t;

    // Receive-side codes (bit 3 clear); bit 0 is the transient busy flag
    localparam code_t C_RX_OFF  = 4'b0000;
    localparam code_t C_EMPTY   = 4'b0100;
    localparam code_t C_FULL    = 4'b0010;
    localparam code_t C_OVRN    = 4'b0110;
    // Transmit-side codes (bit 3 set)
    localparam code_t C_TX_OFF  = 4'b1000;
    localparam code_t C_ABORT   = 4'b1001;
    localparam code_t C_TX_SEND = 4'b1100;
    localparam code_t C_TANS    = 4'b1110;
    localparam code_t C_RANS    = 4'b1010;

    typedef enum logic [EV_W-1:0] {
        EV_NONE    = 3'd0,
        EV_TXDONE  = 3'd1,
        EV_RRMATCH = 3'd2,
        EV_MISTART = 3'd3,
        EV_MIEND   = 3'd4
    } ev_kind_e;

    function automatic logic is_busy(code_t c);
        return !c[3] && c[0];
    endfunction

    function automatic logic rx_ready(code_t c);
        return (c == C_EMPTY) || (c == C_FULL) || (c == C_OVRN);
    endfunction

    function automatic logic tx_ok(code_t c);
        return (c == C_TX_SEND) || (c == C_TANS);
    endfunction

    function automatic code_t read_mask(code_t c, logic aen);
        code_t r;
        r = c;
        if (c[3] && !aen) r[0] = 1'b0;
        return r;
    endfunction

    // Code reached after an automatic event, given the current code and RTR bit
    function automatic code_t auto_next(code_t c, logic rtr, ev_kind_e ev);
        code_t n;
        code_t base;
        n    = c;
        base = {c[3:1], 1'b0};
        case (ev)
            EV_TXDONE: begin
                if (c == C_TX_SEND) n = rtr ? C_EMPTY : C_TX_OFF;
                else if (c == C_TANS) n = C_RANS;
            end
            EV_RRMATCH: begin
                if (c == C_RANS) n = C_TANS;
            end
            EV_MISTART: begin
                if (rx_ready(c)) n = {c[3:1], 1'b1};
            end
            EV_MIEND: begin
                if (is_busy(c)) begin
                    case (base)
                        C_EMPTY: n = C_FULL;
                        C_FULL:  n = C_OVRN;
                        C_OVRN:  n = C_OVRN;
                        default: n = base;
                    endcase
                end
            end
            default: n = c;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/mbc_event_sel.sv
module mbc_event_sel
    import mbc_pkg::*;
#(
    parameter int NUM_MB = 8,
    parameter int IDX_W  = $clog2(NUM_MB)
) (
    input  logic                       tx_vld,
    input  logic [IDX_W-1:0]           tx_idx,
    input  logic                       rr_vld,
    input  logic [IDX_W-1:0]           rr_idx,
    input  logic                       st_vld,
    input  logic [IDX_W-1:0]           st_idx,
    input  logic                       en_vld,
    input  logic [IDX_W-1:0]           en_idx,
    output logic [NUM_MB-1:0][EV_W-1:0] ev_o
);

    for (genvar g = 0; g < NUM_MB; g++) begin : g_sel
        ev_kind_e sel;
        // Later assignments override earlier ones: lowest priority first
        always_comb begin
            sel = EV_NONE;
            if (tx_vld && tx_idx == IDX_W'(g)) sel = EV_TXDONE;
            if (rr_vld && rr_idx == IDX_W'(g)) sel = EV_RRMATCH;
            if (st_vld && st_idx == IDX_W'(g)) sel = EV_MISTART;
            if (en_vld && en_idx == IDX_W'(g)) sel = EV_MIEND;
        end
        assign ev_o[g] = sel;
    end

endmodule

// File: rtl/mbc_mailbox.sv
module mbc_mailbox
    import mbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ev_kind_e ev_i,
    input  logic     wr_hit_i,
    input  code_t    wr_code_i,
    input  logic     wr_rtr_i,
    output code_t    code_o,
    output logic     rtr_o,
    output logic     busy_o,
    output logic     wr_lost_o
);

    code_t code_q;
    logic  rtr_q;
    logic  busy;
    logic  abort_blocked;
    logic  wr_apply;

    assign busy          = is_busy(code_q);
    assign abort_blocked = wr_hit_i && (wr_code_i == C_ABORT) && (code_q == C_RANS);
    assign wr_apply      = wr_hit_i && !busy && !abort_blocked;
    assign wr_lost_o     = wr_hit_i && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= C_RX_OFF;
            rtr_q  <= 1'b0;
        end else if (wr_apply) begin
            code_q <= wr_code_i;
            rtr_q  <= wr_rtr_i;
        end else begin
            code_q <= auto_next(code_q, rtr_q, ev_i);
        end
    end

    assign code_o = code_q;
    assign rtr_o  = rtr_q;
    assign busy_o = busy;

    // R5: base code bits are frozen while busy persists
    p_busy_base_hold_r5: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || code_q[3:1] == $past(code_q[3:1])));

    // R5: busy only appears after a move-in start or an explicit CPU write
    p_busy_rise_src_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ev_i == EV_MISTART || wr_apply));

    // R3: a one-shot data transmit returns to inactive when done
    p_data_done_r3: assert property (@(posedge clk) disable iff (rst)
        (ev_i == EV_TXDONE && !wr_apply && code_q == C_TX_SEND && !rtr_q)
        |=> code_q == C_TX_OFF);

    // R9: abort on an answer-ready mailbox leaves the code alone
    p_abort_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (abort_blocked && ev_i == EV_NONE) |=> code_q == C_RANS);

endmodule

// File: rtl/mbc_read_view.sv
module mbc_read_view
    import mbc_pkg::*;
#(
    parameter int NUM_MB = 8
) (
    input  logic                       abort_en_i,
    input  logic [NUM_MB*CODE_W-1:0]   code_i,
    output logic [NUM_MB*CODE_W-1:0]   rd_code_o,
    output logic [NUM_MB-1:0]          elig_o
);

    for (genvar g = 0; g < NUM_MB; g++) begin : g_view
        code_t c;
        assign c                              = code_i[g*CODE_W +: CODE_W];
        assign rd_code_o[g*CODE_W +: CODE_W]  = read_mask(c, abort_en_i);
        assign elig_o[g]                      = tx_ok(c);
    end

endmodule

// File: rtl/mbc_code_ctrl.sv
module mbc_code_ctrl
    import mbc_pkg::*;
#(
    parameter int NUM_MB = 8,
    parameter int IDX_W  = $clog2(NUM_MB)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     abort_en,
    input  logic                     cpu_wr_en,
    input  logic [IDX_W-1:0]         cpu_wr_idx,
    input  logic [CODE_W-1:0]        cpu_wr_code,
    input  logic                     cpu_wr_rtr,
    input  logic                     tx_done_vld,
    input  logic [IDX_W-1:0]         tx_done_idx,
    input  logic                     rr_match_vld,
    input  logic [IDX_W-1:0]         rr_match_idx,
    input  logic                     mi_start_vld,
    input  logic [IDX_W-1:0]         mi_start_idx,
    input  logic                     mi_end_vld,
    input  logic [IDX_W-1:0]         mi_end_idx,
    output logic [NUM_MB*CODE_W-1:0] mb_code,
    output logic [NUM_MB*CODE_W-1:0] mb_rd_code,
    output logic [NUM_MB-1:0]        tx_eligible,
    output logic [NUM_MB-1:0]        mb_busy,
    output logic                     wr_conflict
);

    logic [NUM_MB-1:0][EV_W-1:0] ev_bus;
    logic [NUM_MB-1:0]           wr_lost;
    logic                        conflict_q;

    mbc_event_sel #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_sel (
        .tx_vld (tx_done_vld),
        .tx_idx (tx_done_idx),
        .rr_vld (rr_match_vld),
        .rr_idx (rr_match_idx),
        .st_vld (mi_start_vld),
        .st_idx (mi_start_idx),
        .en_vld (mi_end_vld),
        .en_idx (mi_end_idx),
        .ev_o   (ev_bus)
    );

    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        code_t code_w;
        logic  rtr_w;
        mbc_mailbox u_mb (
            .clk       (clk),
            .rst       (rst),
            .ev_i      (ev_kind_e'(ev_bus[g])),
            .wr_hit_i  (cpu_wr_en && cpu_wr_idx == IDX_W'(g)),
            .wr_code_i (cpu_wr_code),
            .wr_rtr_i  (cpu_wr_rtr),
            .code_o    (code_w),
            .rtr_o     (rtr_w),
            .busy_o    (mb_busy[g]),
            .wr_lost_o (wr_lost[g])
        );
        assign mb_code[g*CODE_W +: CODE_W] = code_w;
    end

    mbc_read_view #(.NUM_MB(NUM_MB)) u_view (
        .abort_en_i (abort_en),
        .code_i     (mb_code),
        .rd_code_o  (mb_rd_code),
        .elig_o     (tx_eligible)
    );

    always_ff @(posedge clk) begin
        if (rst) conflict_q <= 1'b0;
        else     conflict_q <= |wr_lost;
    end

    assign wr_conflict = conflict_q;

    // R11: a write aimed at a busy mailbox is flagged on the next cycle
    p_conflict_flag_r11: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr_en && mb_busy[cpu_wr_idx]) |=> wr_conflict);

endmodule

// File: tb/mbc_code_ctrl_test.sv
`timescale 1ns/1ps
module mbc_code_ctrl_test;

    localparam int NUM_MB = 8;
    localparam int IDX_W  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic abort_en;
    logic cpu_wr_en;
    logic [IDX_W-1:0] cpu_wr_idx;
    logic [3:0] cpu_wr_code;
    logic cpu_wr_rtr;
    logic tx_done_vld, rr_match_vld, mi_start_vld, mi_end_vld;
    logic [IDX_W-1:0] tx_done_idx, rr_match_idx, mi_start_idx, mi_end_idx;
    logic [NUM_MB*4-1:0] mb_code, mb_rd_code;
    logic [NUM_MB-1:0] tx_eligible, mb_busy;
    logic wr_conflict;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mbc_code_ctrl #(.NUM_MB(NUM_MB)) uut (
        .clk(clk), .rst(rst), .abort_en(abort_en),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_idx(cpu_wr_idx),
        .cpu_wr_code(cpu_wr_code), .cpu_wr_rtr(cpu_wr_rtr),
        .tx_done_vld(tx_done_vld), .tx_done_idx(tx_done_idx),
        .rr_match_vld(rr_match_vld), .rr_match_idx(rr_match_idx),
        .mi_start_vld(mi_start_vld), .mi_start_idx(mi_start_idx),
        .mi_end_vld(mi_end_vld), .mi_end_idx(mi_end_idx),
        .mb_code(mb_code), .mb_rd_code(mb_rd_code),
        .tx_eligible(tx_eligible), .mb_busy(mb_busy),
        .wr_conflict(wr_conflict)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in();
        cpu_wr_en = 0; cpu_wr_idx = '0; cpu_wr_code = '0; cpu_wr_rtr = 0;
        tx_done_vld = 0; tx_done_idx = '0; rr_match_vld = 0; rr_match_idx = '0;
        mi_start_vld = 0; mi_start_idx = '0; mi_end_vld = 0; mi_end_idx = '0;
    endtask

    task automatic fire();
        tick();
        clear_in();
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] code_of(int i);
        return mb_code[i*4 +: 4];
    endfunction

    task automatic wr(int i, logic [3:0] c, logic r);
        cpu_wr_en = 1; cpu_wr_idx = IDX_W'(i); cpu_wr_code = c; cpu_wr_rtr = r;
        fire();
    endtask

    task automatic t_reset();
        chk("R1 codes", mb_code, 32'h0);
        chk("R1 busy", mb_busy, 0);
        chk("R1 eligible", tx_eligible, 0);
        chk("R1 conflict", wr_conflict, 0);
    endtask

    task automatic t_tx();
        wr(2, 4'b1100, 0);
        chk("R2 write data code", code_of(2), 4'b1100);
        chk("R7 send eligible", tx_eligible[2], 1);
        tx_done_vld = 1; tx_done_idx = 2; fire();
        chk("R3 data done -> inactive", code_of(2), 4'b1000);
        chk("R7 inactive not eligible", tx_eligible[2], 0);
        wr(3, 4'b1100, 1);
        tx_done_vld = 1; tx_done_idx = 3; fire();
        chk("R3 remote done -> empty", code_of(3), 4'b0100);
        tx_done_vld = 1; tx_done_idx = 2; fire();
        chk("R3 done on inactive ignored", code_of(2), 4'b1000);
    endtask

    task automatic t_answer();
        wr(4, 4'b1010, 0);
        chk("R7 answer-ready not eligible", tx_eligible[4], 0);
        rr_match_vld = 1; rr_match_idx = 4; fire();
        chk("R4 match -> tanswer", code_of(4), 4'b1110);
        chk("R7 tanswer eligible", tx_eligible[4], 1);
        tx_done_vld = 1; tx_done_idx = 4; fire();
        chk("R3 tanswer done -> ranswer", code_of(4), 4'b1010);
        rr_match_vld = 1; rr_match_idx = 2; fire();
        chk("R4 match on inactive ignored", code_of(2), 4'b1000);
    endtask

    task automatic t_rx();
        mi_start_vld = 1; mi_start_idx = 3; fire();
        chk("R5 start sets busy code", code_of(3), 4'b0101);
        chk("R5 busy flag", mb_busy[3], 1);
        rr_match_vld = 1; rr_match_idx = 3; fire();
        chk("R5 base held while busy", code_of(3), 4'b0101);
        mi_end_vld = 1; mi_end_idx = 3; fire();
        chk("R6 empty -> full", code_of(3), 4'b0010);
        chk("R6 busy cleared", mb_busy[3], 0);
        mi_end_vld = 1; mi_end_idx = 3; fire();
        chk("R6 end without busy ignored", code_of(3), 4'b0010);
        mi_start_vld = 1; mi_start_idx = 3; fire();
        mi_end_vld = 1; mi_end_idx = 3; fire();
        chk("R6 full -> overrun", code_of(3), 4'b0110);
        mi_start_vld = 1; mi_start_idx = 3; fire();
        mi_end_vld = 1; mi_end_idx = 3; fire();
        chk("R6 overrun stays", code_of(3), 4'b0110);
        mi_start_vld = 1; mi_start_idx = 2; fire();
        chk("R5 start on tx code ignored", code_of(2), 4'b1000);
    endtask

    task automatic t_read_view();
        wr(5, 4'b1001, 0);
        abort_en = 0; #1;
        chk("R8 abort busy bit masked", mb_rd_code[5*4 +: 4], 4'b1000);
        abort_en = 1; #1;
        chk("R8 abort busy bit shown", mb_rd_code[5*4 +: 4], 4'b1001);
        abort_en = 0; #1;
        mi_start_vld = 1; mi_start_idx = 3; fire();
        chk("R8 rx busy visible", mb_rd_code[3*4 +: 4], 4'b0111);
    endtask

    task automatic t_abort_ignored();
        wr(4, 4'b1001, 0);
        chk("R9 abort on ranswer ignored", code_of(4), 4'b1010);
        chk("R9 no conflict", wr_conflict, 0);
    endtask

    task automatic t_conflicts();
        wr(6, 4'b1010, 0);
        cpu_wr_en = 1; cpu_wr_idx = 6; cpu_wr_code = 4'b1000;
        rr_match_vld = 1; rr_match_idx = 6; fire();
        chk("R10 cpu write wins", code_of(6), 4'b1000);
        chk("R10 no conflict", wr_conflict, 0);
        // mailbox 3 is busy overrun (0111) from t_read_view
        cpu_wr_en = 1; cpu_wr_idx = 3; cpu_wr_code = 4'b0100;
        mi_end_vld = 1; mi_end_idx = 3; fire();
        chk("R11 event applied, write dropped", code_of(3), 4'b0110);
        chk("R11 conflict raised", wr_conflict, 1);
        tick();
        chk("R11 conflict one cycle", wr_conflict, 0);
    endtask

    task automatic t_priority();
        wr(7, 4'b0100, 0);
        tx_done_vld = 1; tx_done_idx = 7; rr_match_vld = 1; rr_match_idx = 7;
        mi_start_vld = 1; mi_start_idx = 7; fire();
        chk("R12 start over match/done", code_of(7), 4'b0101);
        mi_end_vld = 1; mi_end_idx = 7; mi_start_vld = 1; mi_start_idx = 7; fire();
        chk("R12 end over start", code_of(7), 4'b0010);
        wr(7, 4'b1110, 0);
        tx_done_vld = 1; tx_done_idx = 7; rr_match_vld = 1; rr_match_idx = 7; fire();
        chk("R12 match over done", code_of(7), 4'b1110);
        wr(2, 4'b1100, 0);
        tx_done_vld = 1; tx_done_idx = 2; rr_match_vld = 1; rr_match_idx = 4; fire();
        chk("R12 parallel done mb2", code_of(2), 4'b1000);
        chk("R12 parallel match mb4", code_of(4), 4'b1110);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        abort_en = 0;
        clear_in();
        repeat (3) tick();
        rst = 0;
        tick();
        t_reset();
        t_tx();
        t_answer();
        t_rx();
        t_read_view();
        t_abort_ignored();
        t_conflicts();
        t_priority();
        summary();
        $finish;
    end

endmodule